// File: doc/BRIEF.md
# Write Buffer With Read Bypass

This block sits between a cache and the memory controller and holds stores on their way to memory. Write-through stores and lines evicted dirty from the cache enter a small queue, so the cache does not wait for memory on every write. The queue empties to memory one entry per memory transaction, in arrival order, whenever no read miss is in flight. A store to an address the queue already holds updates that entry's data instead of taking a new slot.

A read miss does not wait for the queue to empty. When a read is accepted, its address is compared against every held entry. On a match, the held data is returned at once and memory is not touched. With no match, the read is sent to memory ahead of every held write, and draining resumes only after the read data has come back. An eviction and its read miss may be presented in the same cycle. The evicted line is queued, the read goes to memory first, and the write-back follows.

The memory port takes a request only in a cycle where it raises `mem_req_ready`. A request that is not taken may be withdrawn. Read data returns on `mem_rsp_valid`. Writes return nothing.

Top module: `wbuf_rdbypass`

## Requirements
- R1: After reset the queue is empty. `wr_ready` and `rd_ready` are high, and `mem_req_valid` and `rd_resp_valid` are low.
- R2: The queue holds up to DEPTH (default 4) distinct addresses. When all slots are occupied, `wr_ready` is low for any address the queue does not hold.
- R3: While no read is outstanding and no read is being offered, a non-empty queue presents its oldest entry on the memory port with `mem_req_write`=1. Each accepted write removes exactly that entry, so entries reach memory in arrival order.
- R4: A store whose address matches a held entry is accepted even when the queue is full. It replaces that entry's data without using a new slot, unless that entry is leaving to memory in the same cycle.
- R5: If a read's address matches a held entry, `rd_resp_valid` rises in the cycle after the read is accepted, carrying that entry's data, and no memory read is issued.
- R6: If a read's address matches no held entry, the read is issued to memory (`mem_req_write`=0) before any held write. No write is drained until the read response has been delivered.
- R7: A store and a read accepted in the same cycle are ordered store first. The store enters the queue and is part of the read's comparison. A queued eviction therefore reaches memory after the read miss that displaced it.
- R8: `rd_ready` is low from the cycle after a read is accepted until its response has been delivered. A memory-served response passes `mem_rsp_data` through in the cycle `mem_rsp_valid` is high.
- R9: No two held entries ever share an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Store or eviction offered |
| wr_ready | output | 1 | Store accepted this cycle when high with wr_valid |
| wr_addr | input | ADDR_W | Line address of the store |
| wr_data | input | DATA_W | Line data of the store |
| rd_valid | input | 1 | Read miss offered |
| rd_ready | output | 1 | Read accepted this cycle when high with rd_valid |
| rd_addr | input | ADDR_W | Line address of the read miss |
| rd_resp_valid | output | 1 | Read data valid |
| rd_resp_data | output | DATA_W | Read data, forwarded or from memory |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory takes the request this cycle |
| mem_req_write | output | 1 | 1 for a write, 0 for a read |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_wdata | output | DATA_W | Write data, zero for reads |
| mem_rsp_valid | input | 1 | Read data from memory valid |
| mem_rsp_data | input | DATA_W | Read data from memory |

## Verification
Two collisions can land on the same clock edge: a read acceptance together with a store, and a store merge together with the queue head leaving to memory. The first is provoked by offering an eviction and an unrelated read miss in one cycle, and by offering a store and a read to one address in one cycle. The first case is judged by the order of the logged memory transactions, read before write-back. The second case is judged by the forwarded data being the store's own data. Merging while full and stalling while full are probed on the ready signal with the memory port held off. The drained address and data sequence then shows whether each merged value landed in the right slot.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    RD_IDLE   = 2'd0,
    RD_LOOKUP = 2'd1,
    RD_ISSUE  = 2'd2,
    RD_WAIT   = 2'd3
  } rd_state_e;
endpackage

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  output logic              merge_hit,
  input  logic              pop,
  output logic              nonempty,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  input  logic [ADDR_W-1:0] look_addr,
  output logic [DEPTH-1:0]  look_vec,
  output logic              look_hit,
  output logic [DATA_W-1:0] look_data,
  output logic [CNT_W-1:0]  count
);

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  vld_q, vld_d;
  logic [PTR_W-1:0]  head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DEPTH-1:0]  mrg_vec, data_we, addr_we;
  logic              full, push_fire, alloc;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  // address comparators: merge side excludes a slot leaving this cycle
  always_comb begin
    mrg_vec  = '0;
    look_vec = '0;
    for (int i = 0; i < DEPTH; i++) begin
      mrg_vec[i]  = vld_q[i] && (addr_q[i] == push_addr) &&
                    !(pop && (head_q == PTR_W'(i)));
      look_vec[i] = vld_q[i] && (addr_q[i] == look_addr);
    end
  end

  always_comb begin
    look_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (look_vec[i]) look_data = look_data | data_q[i];
    end
  end

  assign merge_hit  = |mrg_vec;
  assign look_hit   = |look_vec;
  assign full       = (cnt_q == CNT_W'(DEPTH));
  assign push_ready = !full || merge_hit;
  assign push_fire  = push_valid && push_ready;
  assign alloc      = push_fire && !merge_hit;
  assign nonempty   = (cnt_q != '0);
  assign head_addr  = addr_q[head_q];
  assign head_data  = data_q[head_q];
  assign count      = cnt_q;

  // next-state
  always_comb begin
    vld_d  = vld_q;
    head_d = head_q;
    tail_d = tail_q;
    for (int i = 0; i < DEPTH; i++) begin
      addr_we[i] = alloc && (tail_q == PTR_W'(i));
      data_we[i] = addr_we[i] || (push_fire && mrg_vec[i]);
    end
    if (pop) begin
      vld_d[head_q] = 1'b0;
      head_d        = ptr_inc(head_q);
    end
    if (alloc) begin
      vld_d[tail_q] = 1'b1;
      tail_d        = ptr_inc(tail_q);
    end
    cnt_d = cnt_q + CNT_W'(alloc) - CNT_W'(pop);
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      vld_q  <= vld_d;
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  // slot payload registers, enabled per slot
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (addr_we[g]) addr_q[g] <= push_addr;
      if (data_we[g]) data_q[g] <= push_data;
    end
  end

endmodule

// File: rtl/wbuf_rd_ctrl.sv
module wbuf_rd_ctrl
  import wbuf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] look_addr,
  input  logic              look_hit,
  input  logic [DATA_W-1:0] look_data,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic              rd_quiet,
  output logic              rd_busy
);

  rd_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              addr_en;

  assign rd_ready  = (state_q == RD_IDLE);
  assign addr_en   = rd_valid && rd_ready;
  assign look_addr = addr_q;
  assign rd_quiet  = (state_q == RD_IDLE) && !rd_valid;
  assign rd_busy   = (state_q != RD_IDLE);

  always_comb begin
    state_d      = state_q;
    resp_valid   = 1'b0;
    resp_data    = look_data;
    mem_rd_valid = 1'b0;
    case (state_q)
      RD_IDLE:   if (rd_valid) state_d = RD_LOOKUP;
      RD_LOOKUP: begin
        if (look_hit) begin
          resp_valid = 1'b1;
          state_d    = RD_IDLE;
        end else begin
          state_d    = RD_ISSUE;
        end
      end
      RD_ISSUE: begin
        mem_rd_valid = 1'b1;
        if (mem_rd_ready) state_d = RD_WAIT;
      end
      RD_WAIT: begin
        if (mem_rsp_valid) begin
          resp_valid = 1'b1;
          resp_data  = mem_rsp_data;
          state_d    = RD_IDLE;
        end
      end
      default: state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RD_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (addr_en) addr_q <= rd_addr;
  end

endmodule

// File: rtl/wbuf_mem_arb.sv
module wbuf_mem_arb #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              mem_rd_valid,
  output logic              mem_rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              drain_ok,
  input  logic              nonempty,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic [DATA_W-1:0] head_data,
  output logic              pop,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata
);

  logic drain_valid;

  assign drain_valid   = drain_ok && nonempty && !mem_rd_valid;
  assign mem_req_valid = mem_rd_valid || drain_valid;
  assign mem_req_write = !mem_rd_valid;
  assign mem_req_addr  = mem_rd_valid ? rd_addr : head_addr;
  assign mem_req_wdata = mem_rd_valid ? '0 : head_data;
  assign mem_rd_ready  = mem_rd_valid && mem_req_ready;
  assign pop           = drain_valid && mem_req_ready;

endmodule

// File: rtl/wbuf_rdbypass.sv
module wbuf_rdbypass #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_resp_valid,
  output logic [DATA_W-1:0] rd_resp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              merge_hit, pop, nonempty, look_hit;
  logic              mem_rd_valid, mem_rd_ready, rd_quiet, rd_busy;
  logic [ADDR_W-1:0] head_addr, look_addr;
  logic [DATA_W-1:0] head_data, look_data;
  logic [DEPTH-1:0]  look_vec;
  logic [CNT_W-1:0]  count;

  wbuf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (wr_valid),
    .push_ready (wr_ready),
    .push_addr  (wr_addr),
    .push_data  (wr_data),
    .merge_hit  (merge_hit),
    .pop        (pop),
    .nonempty   (nonempty),
    .head_addr  (head_addr),
    .head_data  (head_data),
    .look_addr  (look_addr),
    .look_vec   (look_vec),
    .look_hit   (look_hit),
    .look_data  (look_data),
    .count      (count)
  );

  wbuf_rd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_valid      (rd_valid),
    .rd_ready      (rd_ready),
    .rd_addr       (rd_addr),
    .look_addr     (look_addr),
    .look_hit      (look_hit),
    .look_data     (look_data),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .resp_valid    (rd_resp_valid),
    .resp_data     (rd_resp_data),
    .rd_quiet      (rd_quiet),
    .rd_busy       (rd_busy)
  );

  wbuf_mem_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .rd_addr       (look_addr),
    .drain_ok      (rd_quiet),
    .nonempty      (nonempty),
    .head_addr     (head_addr),
    .head_data     (head_data),
    .pop           (pop),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata)
  );

endmodule

// File: rtl/wbuf_rdbypass_chk.sv
module wbuf_rdbypass_chk #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic             mem_req_valid,
  input logic             mem_req_write,
  input logic             merge_hit,
  input logic             pop,
  input logic             rd_busy,
  input logic [DEPTH-1:0] look_vec,
  input logic [CNT_W-1:0] count
);

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  p_pop_shrinks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !(wr_valid && wr_ready && !merge_hit)) |=> (count == $past(count) - CNT_W'(1)));

  p_merge_no_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && merge_hit && !pop) |=> (count == $past(count)));

  p_no_drain_in_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_busy |-> !(mem_req_valid && mem_req_write));

  p_one_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> !rd_ready);

  p_unique_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_vec));

endmodule

bind wbuf_rdbypass wbuf_rdbypass_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_valid      (wr_valid),
  .wr_ready      (wr_ready),
  .rd_valid      (rd_valid),
  .rd_ready      (rd_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_write (mem_req_write),
  .merge_hit     (merge_hit),
  .pop           (pop),
  .rd_busy       (rd_busy),
  .look_vec      (look_vec),
  .count         (count)
);

// File: tb/wbuf_rdbypass_tb.sv
`timescale 1ns/1ps
module wbuf_rdbypass_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid, wr_ready;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;
  logic        rd_valid, rd_ready;
  logic [15:0] rd_addr;
  logic        rd_resp_valid;
  logic [31:0] rd_resp_data;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [15:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  always #2 clk = ~clk;

  wbuf_rdbypass u_dut (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // memory model and logs
  logic        log_w [256];
  logic [15:0] log_a [256];
  logic [31:0] log_d [256];
  int          nlog = 0;
  int          lat = 0;
  logic [15:0] pend_a;
  int          nresp = 0;
  logic [31:0] last_resp;
  int          nlog_at_resp = 0;

  function automatic logic [31:0] mfn(input logic [15:0] a);
    return {a ^ 16'hA5C3, a};
  endfunction

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (lat > 0) begin
      lat <= lat - 1;
      if (lat == 1) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mfn(pend_a);
      end
    end
    if (rst_n && mem_req_valid && mem_req_ready && nlog < 256) begin
      log_w[nlog] <= mem_req_write;
      log_a[nlog] <= mem_req_addr;
      log_d[nlog] <= mem_req_wdata;
      nlog        <= nlog + 1;
      if (!mem_req_write) begin
        lat    <= 3;
        pend_a <= mem_req_addr;
      end
    end
    if (rst_n && rd_resp_valid) begin
      nresp        <= nresp + 1;
      last_resp    <= rd_resp_data;
      nlog_at_resp <= nlog;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    #1;
    while (!wr_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic issue_read(input logic [15:0] a);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a;
    #1;
    while (!rd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic wait_resp(input int n0);
    for (int i = 0; i < 40 && nresp == n0; i++) @(negedge clk);
  endtask

  function automatic int reads_in(input int from);
    int k = 0;
    for (int i = from; i < nlog; i++) if (!log_w[i]) k++;
    return k;
  endfunction

  task automatic t_reset;
    chk("R1 wr_ready", wr_ready, 1);
    chk("R1 rd_ready", rd_ready, 1);
    chk("R1 mem_req_valid", mem_req_valid, 0);
    chk("R1 rd_resp_valid", rd_resp_valid, 0);
  endtask

  task automatic t_fill_stall_drain;
    int base;
    mem_req_ready = 1'b0;
    for (int i = 0; i < 4; i++) put(16'h0100 + 16'(i), 32'h1000 + 32'(i));
    wr_valid = 1'b1; wr_addr = 16'h0999; wr_data = 32'hDEAD;
    #1 chk("R2 full stalls new address", wr_ready, 0);
    wr_addr = 16'h0101; wr_data = 32'hBEEF0101;
    #1 chk("R4 full accepts held address", wr_ready, 1);
    @(negedge clk);
    wr_addr = 16'h0999;
    #1 chk("R2 still full after merge", wr_ready, 0);
    wr_valid = 1'b0;
    base = nlog;
    mem_req_ready = 1'b1;
    repeat (8) @(negedge clk);
    chk("R3 drain count", nlog - base, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R3 drain is write", log_w[base+i], 1);
      chk("R3 drain order", log_a[base+i], 16'h0100 + 16'(i));
      chk("R4 drain data", log_d[base+i], (i == 1) ? 32'hBEEF0101 : 32'h1000 + 32'(i));
    end
    chk("R3 idle after drain", mem_req_valid, 0);
  endtask

  task automatic t_merge;
    int base;
    mem_req_ready = 1'b0;
    put(16'h0200, 32'h2000);
    put(16'h0201, 32'h2001);
    put(16'h0200, 32'h2FFF);
    put(16'h0201, 32'h2EEE);
    base = nlog;
    mem_req_ready = 1'b1;
    repeat (6) @(negedge clk);
    chk("R9 merged entries no duplicate", nlog - base, 2);
    chk("R4 merged head addr", log_a[base], 16'h0200);
    chk("R4 merged head data", log_d[base], 32'h2FFF);
    chk("R4 merged second data", log_d[base+1], 32'h2EEE);
  endtask

  task automatic t_forward;
    int base;
    int n0;
    mem_req_ready = 1'b0;
    put(16'h0300, 32'h3333);
    put(16'h0301, 32'h3131);
    base = nlog;
    n0 = nresp;
    issue_read(16'h0301);
    chk("R5 forward valid one cycle later", rd_resp_valid, 1);
    chk("R5 forward data", rd_resp_data, 32'h3131);
    mem_req_ready = 1'b1;
    repeat (6) @(negedge clk);
    chk("R5 one response", nresp - n0, 1);
    chk("R5 no memory read", reads_in(base), 0);
    chk("R5 buffer still drains", nlog - base, 2);
  endtask

  task automatic t_bypass;
    int base;
    int n0;
    mem_req_ready = 1'b0;
    put(16'h0400, 32'h4000);
    put(16'h0401, 32'h4001);
    put(16'h0402, 32'h4002);
    base = nlog;
    n0 = nresp;
    issue_read(16'h0777);
    chk("R8 rd_ready low while outstanding", rd_ready, 0);
    chk("R6 miss gives no early response", rd_resp_valid, 0);
    repeat (2) @(negedge clk);
    mem_req_ready = 1'b1;
    wait_resp(n0);
    @(negedge clk);
    chk("R8 response data from memory", last_resp, mfn(16'h0777));
    chk("R6 read first on memory", log_w[base], 0);
    chk("R6 read address", log_a[base], 16'h0777);
    chk("R6 no write before response", nlog_at_resp - base, 1);
    repeat (6) @(negedge clk);
    chk("R6 writes drain afterwards", nlog - base, 4);
    for (int i = 0; i < 3; i++)
      chk("R6 drain order after read", log_a[base+1+i], 16'h0400 + 16'(i));
    chk("R8 rd_ready back", rd_ready, 1);
  endtask

  task automatic t_victim;
    int base;
    int n0;
    mem_req_ready = 1'b1;
    base = nlog;
    n0 = nresp;
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 16'h0500; wr_data = 32'h5050;
    rd_valid = 1'b1; rd_addr = 16'h0888;
    #1 chk("R7 both accepted", {wr_ready, rd_ready}, 2'b11);
    @(negedge clk);
    wr_valid = 1'b0; rd_valid = 1'b0;
    wait_resp(n0);
    repeat (4) @(negedge clk);
    chk("R7 read miss data", last_resp, mfn(16'h0888));
    chk("R7 read goes first", log_w[base], 0);
    chk("R7 read address", log_a[base], 16'h0888);
    chk("R7 eviction after read", {log_w[base+1], log_a[base+1]}, {1'b1, 16'h0500});
    chk("R7 eviction data", log_d[base+1], 32'h5050);
  endtask

  task automatic t_same_addr;
    int base;
    base = nlog;
    mem_req_ready = 1'b1;
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 16'h0600; wr_data = 32'h6066;
    rd_valid = 1'b1; rd_addr = 16'h0600;
    @(negedge clk);
    wr_valid = 1'b0; rd_valid = 1'b0;
    chk("R7 same-cycle store forwarded", rd_resp_valid, 1);
    chk("R7 same-cycle store data", rd_resp_data, 32'h6066);
    repeat (4) @(negedge clk);
    chk("R7 no memory read for same-cycle store", reads_in(base), 0);
    chk("R7 store drained", nlog - base, 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
    rd_valid = 1'b0; rd_addr = '0;
    mem_req_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_stall_drain();
    t_merge();
    t_forward();
    t_bypass();
    t_victim();
    t_same_addr();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule